// File: doc/BRIEF.md
# Dual-Protocol Serial Register Front-End

This block sits between a processor's register bus and two serial protocol engines: a 2-wire (I2C-style) controller and an SPI controller. It owns an 8-bit control register. It routes accesses at a shared status address and a shared buffer address to whichever engine is active. It merges the engines' event flags into a single interrupt request. It takes over the upper pins of a general-purpose port whenever the serial function is switched on.

At reset the control register is not loaded with constants. It takes its value from an external 8-bit strap bus, and a pair of boot-mode strap pins are captured at the same moment. A small state machine, with the states `ST_CAPTURE` and `ST_RUN`, does the capture. While reset is held, the machine stays in `ST_CAPTURE`, and `strap_sample` tells the board logic to keep the strap bus as an input. On the first clock edge after reset is released, the transition `T_RELEASE` loads the straps and moves to `ST_RUN`. From then on the only transition is `T_HOLD`, which keeps the machine in `ST_RUN`. The engines themselves sit outside this block.

Top module: `srf_frontend`

## Requirements
- R1: While reset is asserted, `strap_sample` is 1 and the control register reads 0. On the first rising clock edge after reset is released, the control register loads `strap_bus` with bit 3 (output enable) forced to 0, and `strap_sample` drops to 0. Later changes on `strap_bus` have no effect.
- R2: Address 0 is the control register, and it reads back whatever was last written. Its bit fields are: bit 7 enable, bit 6 protocol (1 = 2-wire, 0 = SPI), bit 5 boot master, bit 4 interrupt enable, bit 3 output enable, bit 2 open-drain, bit 1 ROM map, bit 0 boot baud.
- R3: Address 1 goes to the 2-wire status target (index 0) when bit 6 is 1, and to the SPI status target (index 1) when bit 6 is 0.
- R4: Address 2 goes to the SPI buffer target (index 4) when bit 6 is 0. When bit 6 is 1, it goes to the 2-wire data buffer target (index 2) if `tw_bus_busy` is 1, and to the device-address target (index 3) if `tw_bus_busy` is 0. A read returns the byte `eng_rdata[8k+7:8k]` of the chosen target k.
- R5: Address 3 reads `{6'b0, boot_q}`, where `boot_q` holds the `boot_strap` value captured with R1. Writes to address 3 change nothing.
- R6: `irq` is 0 whenever bit 4 is 0. Otherwise it is `spi_ccf | spi_modf | spi_wcol` when bit 6 is 0, and `tw_ccf | tw_err` when bit 6 is 1.
- R7: With bit 7 at 0, every pad i takes `pad_oe[i] = ~gp_dir[i]` (1 means input), `pad_out[i] = gp_dout[i]` and `pad_od[i]` = bit 2.
- R8: With bit 7 at 1 and bit 6 at 0, pins 7, 6 and 5 carry clock, MOSI and MISO (`spi_drv_o/oe[0..2]`), and pin 4 (select) is forced to input with its output at 0. `gp_dir` and `gp_dout` are ignored on these pins, and pins 3..0 behave as in R7.
- R9: With bit 7 at 1 and bit 6 at 1, pins 7 and 6 carry clock and data (`tw_drv_o[0..1]`) with `pad_oe` = 1 and `pad_od` = 1, whatever the values of `gp_dir` and bit 2. Pins 5..0 behave as in R7.
- R10: While bit 3 is 0, every bit of `pad_oe` is 0.
- R11: `tgt_wr` and `tgt_rd` are each at most one-hot. They pulse only during `cpu_wr` or `cpu_rd` respectively, and are all 0 at addresses 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_bus | input | 8 | Control-register default, sampled at capture |
| boot_strap | input | 2 | Boot-mode straps, sampled at capture |
| strap_sample | output | 1 | High while straps are being sampled |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| tgt_wr | output | 5 | Per-target write strobes |
| tgt_rd | output | 5 | Per-target read strobes |
| tgt_wdata | output | 8 | Write data to targets |
| eng_rdata | input | 40 | Read data from the five targets, 8 bits each |
| tw_bus_busy | input | 1 | 2-wire bus busy |
| tw_ccf | input | 1 | 2-wire transfer complete |
| tw_err | input | 1 | 2-wire error |
| spi_ccf | input | 1 | SPI transfer complete |
| spi_modf | input | 1 | SPI mode fault |
| spi_wcol | input | 1 | SPI write collision |
| irq | output | 1 | Combined interrupt request |
| gp_dir | input | 8 | Port direction register (1 = input) |
| gp_dout | input | 8 | Port data register |
| spi_drv_o | input | 3 | SPI engine pin values (clock, MOSI, MISO) |
| spi_drv_oe | input | 3 | SPI engine pin enables |
| tw_drv_o | input | 2 | 2-wire engine pin values (clock, data) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_od | output | 8 | Pad open-drain selects |

## Verification
If the capture machine is stuck in `ST_CAPTURE`, `strap_sample` stays high on the first sample after reset is released. All control writes are then lost, which shows on the very next readback. A corrupted control register shows up within the same cycle: on the pads under the full sweep of control values, on the routed strobe, or on `irq`. A wrong busy or protocol decode lands a strobe on the wrong target index in the cycle of the access. An output-enable gate that lets a pin leak through is visible on `pad_oe` as soon as the output-enable bit is cleared.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int DATA_W = 8;
    localparam int PORT_W = 8;
    localparam int BOOT_W = 2;
    localparam int ADDR_W = 2;
    localparam int NTGT   = 5;

    // control-register field positions
    localparam int B_EN   = 7;
    localparam int B_SEL  = 6;
    localparam int B_BMST = 5;
    localparam int B_IE   = 4;
    localparam int B_GOE  = 3;
    localparam int B_ODS  = 2;
    localparam int B_ROM  = 1;
    localparam int B_BAUD = 0;

    // routing target indices
    localparam int T_TW_STAT  = 0;
    localparam int T_SPI_STAT = 1;
    localparam int T_TW_BUF   = 2;
    localparam int T_TW_ADR   = 3;
    localparam int T_SPI_BUF  = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_BUF  = 2'd2,
        RA_BOOT = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_CAPTURE = 1'b0,
        ST_RUN     = 1'b1
    } cap_state_e;
endpackage

// File: rtl/srf_ctrl_reg.sv
module srf_ctrl_reg
    import srf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BOOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] strap_bus,
    input  logic [BW-1:0] boot_strap,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic [BW-1:0] boot_q,
    output logic          strap_sample
);
    localparam logic [DW-1:0] GOE_MASK = DW'(1) << B_GOE;

    cap_state_e state_q, state_d;
    logic       load_strap;
    logic       write_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CAPTURE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        load_strap   = 1'b0;
        strap_sample = 1'b0;
        write_ok     = 1'b0;
        unique case (state_q)
            ST_CAPTURE: begin
                load_strap   = 1'b1;
                strap_sample = 1'b1;
                state_d      = ST_RUN;   // T_RELEASE
            end
            ST_RUN: begin
                write_ok     = 1'b1;
                state_d      = ST_RUN;   // T_HOLD
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            boot_q <= '0;
        end else if (load_strap) begin
            ctrl_q <= strap_bus & ~GOE_MASK;
            boot_q <= boot_strap;
        end else if (wr_en && write_ok) begin
            ctrl_q <= wdata;
        end
    end
endmodule

// File: rtl/srf_steer.sv
module srf_steer
    import srf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NT = NTGT
) (
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               proto_tw,
    input  logic               bus_busy,
    input  logic [NT*DW-1:0]   eng_rdata,
    output logic [NT-1:0]      tgt_wr,
    output logic [NT-1:0]      tgt_rd,
    output logic [DW-1:0]      sel_rdata,
    input  logic               irq_en,
    input  logic               tw_ccf,
    input  logic               tw_err,
    input  logic               spi_ccf,
    input  logic               spi_modf,
    input  logic               spi_wcol,
    output logic               irq
);
    logic [NT-1:0] hit;

    always_comb begin
        hit = '0;
        unique case (reg_addr_e'(cpu_addr))
            RA_STAT: hit[proto_tw ? T_TW_STAT : T_SPI_STAT] = 1'b1;
            RA_BUF: begin
                if (!proto_tw)     hit[T_SPI_BUF] = 1'b1;
                else if (bus_busy) hit[T_TW_BUF]  = 1'b1;
                else               hit[T_TW_ADR]  = 1'b1;
            end
            RA_CTRL, RA_BOOT: hit = '0;
        endcase
    end

    assign tgt_wr = hit & {NT{cpu_wr}};
    assign tgt_rd = hit & {NT{cpu_rd}};

    always_comb begin
        sel_rdata = '0;
        for (int k = 0; k < NT; k++) begin
            if (hit[k]) sel_rdata = sel_rdata | eng_rdata[k*DW +: DW];
        end
    end

    assign irq = irq_en & (proto_tw ? (tw_ccf | tw_err)
                                    : (spi_ccf | spi_modf | spi_wcol));
endmodule

// File: rtl/srf_pin_mux.sv
module srf_pin_mux
    import srf_pkg::*;
#(
    parameter int PW = PORT_W
) (
    input  logic          en,
    input  logic          proto_tw,
    input  logic          goe,
    input  logic          ods,
    input  logic [PW-1:0] gp_dir,
    input  logic [PW-1:0] gp_dout,
    input  logic [2:0]    spi_drv_o,
    input  logic [2:0]    spi_drv_oe,
    input  logic [1:0]    tw_drv_o,
    output logic [PW-1:0] pad_out,
    output logic [PW-1:0] pad_oe,
    output logic [PW-1:0] pad_od
);
    localparam int SPI_PINS = 4;
    localparam int TW_PINS  = 2;

    for (genvar g = 0; g < PW; g++) begin : g_pin
        logic oe_r, out_r, od_r;
        localparam int J = PW - 1 - g;

        if (g >= PW - TW_PINS) begin : g_tw
            always_comb begin
                oe_r  = ~gp_dir[g];
                out_r = gp_dout[g];
                od_r  = ods;
                if (en && proto_tw) begin
                    oe_r  = 1'b1;
                    out_r = tw_drv_o[J];
                    od_r  = 1'b1;
                end else if (en) begin
                    oe_r  = spi_drv_oe[J];
                    out_r = spi_drv_o[J];
                end
            end
        end else if (g >= PW - SPI_PINS + 1) begin : g_spi
            always_comb begin
                oe_r  = ~gp_dir[g];
                out_r = gp_dout[g];
                od_r  = ods;
                if (en && !proto_tw) begin
                    oe_r  = spi_drv_oe[J];
                    out_r = spi_drv_o[J];
                end
            end
        end else if (g == PW - SPI_PINS) begin : g_sel
            always_comb begin
                oe_r  = ~gp_dir[g];
                out_r = gp_dout[g];
                od_r  = ods;
                if (en && !proto_tw) begin
                    oe_r  = 1'b0;
                    out_r = 1'b0;
                end
            end
        end else begin : g_gp
            always_comb begin
                oe_r  = ~gp_dir[g];
                out_r = gp_dout[g];
                od_r  = ods;
            end
        end

        assign pad_oe[g]  = oe_r & goe;
        assign pad_out[g] = out_r;
        assign pad_od[g]  = od_r;
    end
endmodule

// File: rtl/srf_frontend.sv
module srf_frontend
    import srf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PORT_W,
    parameter int BW = BOOT_W,
    parameter int NT = NTGT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     strap_bus,
    input  logic [BW-1:0]     boot_strap,
    output logic              strap_sample,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic [NT-1:0]     tgt_wr,
    output logic [NT-1:0]     tgt_rd,
    output logic [DW-1:0]     tgt_wdata,
    input  logic [NT*DW-1:0]  eng_rdata,
    input  logic              tw_bus_busy,
    input  logic              tw_ccf,
    input  logic              tw_err,
    input  logic              spi_ccf,
    input  logic              spi_modf,
    input  logic              spi_wcol,
    output logic              irq,
    input  logic [PW-1:0]     gp_dir,
    input  logic [PW-1:0]     gp_dout,
    input  logic [2:0]        spi_drv_o,
    input  logic [2:0]        spi_drv_oe,
    input  logic [1:0]        tw_drv_o,
    output logic [PW-1:0]     pad_out,
    output logic [PW-1:0]     pad_oe,
    output logic [PW-1:0]     pad_od
);
    logic [DW-1:0] ctrl_q;
    logic [BW-1:0] boot_q;
    logic [DW-1:0] eng_sel_rdata;
    logic          ctrl_wr;

    assign ctrl_wr   = cpu_wr && (reg_addr_e'(cpu_addr) == RA_CTRL);
    assign tgt_wdata = cpu_wdata;

    srf_ctrl_reg #(.DW(DW), .BW(BW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_bus    (strap_bus),
        .boot_strap   (boot_strap),
        .wr_en        (ctrl_wr),
        .wdata        (cpu_wdata),
        .ctrl_q       (ctrl_q),
        .boot_q       (boot_q),
        .strap_sample (strap_sample)
    );

    srf_steer #(.DW(DW), .NT(NT)) u_steer (
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .proto_tw  (ctrl_q[B_SEL]),
        .bus_busy  (tw_bus_busy),
        .eng_rdata (eng_rdata),
        .tgt_wr    (tgt_wr),
        .tgt_rd    (tgt_rd),
        .sel_rdata (eng_sel_rdata),
        .irq_en    (ctrl_q[B_IE]),
        .tw_ccf    (tw_ccf),
        .tw_err    (tw_err),
        .spi_ccf   (spi_ccf),
        .spi_modf  (spi_modf),
        .spi_wcol  (spi_wcol),
        .irq       (irq)
    );

    srf_pin_mux #(.PW(PW)) u_pins (
        .en         (ctrl_q[B_EN]),
        .proto_tw   (ctrl_q[B_SEL]),
        .goe        (ctrl_q[B_GOE]),
        .ods        (ctrl_q[B_ODS]),
        .gp_dir     (gp_dir),
        .gp_dout    (gp_dout),
        .spi_drv_o  (spi_drv_o),
        .spi_drv_oe (spi_drv_oe),
        .tw_drv_o   (tw_drv_o),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_od     (pad_od)
    );

    always_comb begin
        unique case (reg_addr_e'(cpu_addr))
            RA_CTRL:         cpu_rdata = ctrl_q;
            RA_BOOT:         cpu_rdata = DW'(boot_q);
            RA_STAT, RA_BUF: cpu_rdata = eng_sel_rdata;
        endcase
    end
endmodule

// File: rtl/srf_frontend_chk.sv
module srf_frontend_chk #(
    parameter int PW = 8,
    parameter int NT = 5,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [NT-1:0] tgt_wr,
    input logic [NT-1:0] tgt_rd,
    input logic          en,
    input logic          sel,
    input logic          ie,
    input logic          goe,
    input logic [BW-1:0] boot_q,
    input logic          strap_sample,
    input logic [PW-1:0] pad_oe,
    input logic [PW-1:0] pad_od,
    input logic          irq
);
    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_wr)); // R11
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_rd)); // R11
    AST_WR_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> (tgt_wr == '0)); // R11
    AST_RD_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> (tgt_rd == '0)); // R11
    AST_GOE_CLEARED_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strap_sample) |-> !goe); // R1
    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_sample |=> $stable(boot_q)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq); // R6
    AST_SPI_SELECT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel) |-> !pad_oe[PW-4]); // R8
    AST_TW_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel) |-> (pad_od[PW-1:PW-2] == 2'b11)); // R9
    AST_GOE_GATES_PADS: assert property (@(posedge clk) disable iff (!rst_n)
        !goe |-> (pad_oe == '0)); // R10
endmodule

bind srf_frontend srf_frontend_chk #(.PW(PW), .NT(NT), .BW(BW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .tgt_wr       (tgt_wr),
    .tgt_rd       (tgt_rd),
    .en           (ctrl_q[7]),
    .sel          (ctrl_q[6]),
    .ie           (ctrl_q[4]),
    .goe          (ctrl_q[3]),
    .boot_q       (boot_q),
    .strap_sample (strap_sample),
    .pad_oe       (pad_oe),
    .pad_od       (pad_od),
    .irq          (irq)
);

// File: tb/srf_frontend_bench.sv
module srf_frontend_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  strap_bus = '0;
    logic [1:0]  boot_strap = '0;
    logic        strap_sample;
    logic [1:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [4:0]  tgt_wr, tgt_rd;
    logic [7:0]  tgt_wdata;
    logic [39:0] eng_rdata = {8'hE4, 8'hD3, 8'hC2, 8'hB1, 8'hA0};
    logic        tw_bus_busy = 1'b0;
    logic        tw_ccf = 0, tw_err = 0, spi_ccf = 0, spi_modf = 0, spi_wcol = 0;
    logic        irq;
    logic [7:0]  gp_dir = '0, gp_dout = '0;
    logic [2:0]  spi_drv_o = '0, spi_drv_oe = '0;
    logic [1:0]  tw_drv_o = '0;
    logic [7:0]  pad_out, pad_oe, pad_od;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    srf_frontend u_srf_frontend (
        .clk(clk), .rst_n(rst_n), .strap_bus(strap_bus), .boot_strap(boot_strap),
        .strap_sample(strap_sample), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tgt_wr(tgt_wr), .tgt_rd(tgt_rd), .tgt_wdata(tgt_wdata),
        .eng_rdata(eng_rdata), .tw_bus_busy(tw_bus_busy), .tw_ccf(tw_ccf),
        .tw_err(tw_err), .spi_ccf(spi_ccf), .spi_modf(spi_modf),
        .spi_wcol(spi_wcol), .irq(irq), .gp_dir(gp_dir), .gp_dout(gp_dout),
        .spi_drv_o(spi_drv_o), .spi_drv_oe(spi_drv_oe), .tw_drv_o(tw_drv_o),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    // expected pads {oe, out, od}, written from R7..R10
    function automatic logic [23:0] exp_pads(input logic [7:0] c);
        logic [7:0] oe, out, od;
        for (int i = 0; i < 8; i++) begin
            oe[i] = ~gp_dir[i]; out[i] = gp_dout[i]; od[i] = c[2];
            if (c[7] && c[6] && i >= 6) begin
                oe[i] = 1'b1; out[i] = tw_drv_o[7-i]; od[i] = 1'b1;
            end else if (c[7] && !c[6] && i >= 5) begin
                oe[i] = spi_drv_oe[7-i]; out[i] = spi_drv_o[7-i];
            end else if (c[7] && !c[6] && i == 4) begin
                oe[i] = 1'b0; out[i] = 1'b0;
            end
        end
        if (!c[3]) oe = '0;
        return {oe, out, od};
    endfunction

    task automatic do_reset(input logic [7:0] s, input logic [1:0] b);
        logic [7:0] v;
        @(negedge clk);
        rst_n = 1'b0; strap_bus = s; boot_strap = b;
        repeat (2) @(negedge clk);
        #1;
        chk(strap_sample == 1'b1, "R1 sample during reset", strap_sample, 1);
        rd_reg(2'd0, v);
        chk(v == 8'h00, "R1 ctrl during reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(strap_sample == 1'b0, "R1 sample after release", strap_sample, 0);
        rd_reg(2'd0, v);
        chk(v == (s & 8'hF7), "R1 captured ctrl", v, s & 8'hF7);
        rd_reg(2'd3, v);
        chk(v == {6'b0, b}, "R5 captured boot", v, {6'b0, b});
        strap_bus = ~s; boot_strap = ~b;
        repeat (2) @(negedge clk); #1;
        rd_reg(2'd0, v);
        chk(v == (s & 8'hF7), "R1 strap ignored later", v, s & 8'hF7);
        rd_reg(2'd3, v);
        chk(v == {6'b0, b}, "R5 boot held", v, {6'b0, b});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        do_reset(8'hFF, 2'b10);
        do_reset(8'h5A, 2'b01);

        // R5: writes to address 3 are ignored
        wr_reg(2'd3, 8'hFF);
        #1 rd_reg(2'd3, v);
        chk(v == 8'h01, "R5 write ignored", v, 8'h01);

        // R2, R7, R8, R9, R10: sweep every control value
        for (int c = 0; c < 256; c++) begin
            wr_reg(2'd0, 8'(c));
            #1 rd_reg(2'd0, v);
            chk(v == 8'(c), "R2 ctrl readback", v, c);
            for (int e = 0; e < 4; e++) begin
                logic [23:0] ex;
                gp_dir     = 8'h5A ^ 8'(e * 8'h37);
                gp_dout    = 8'hC3 ^ 8'(e * 8'h29);
                spi_drv_o  = 3'(e + c);
                spi_drv_oe = ~3'(e * 3 + c);
                tw_drv_o   = 2'(e ^ c);
                #1 ex = exp_pads(8'(c));
                chk({pad_oe, pad_out, pad_od} == ex,
                    c[3] ? (c[7] ? (c[6] ? "R9 2-wire pins" : "R8 SPI pins") : "R7 port pins")
                         : "R10 outputs gated",
                    {8'h0, pad_oe, pad_out, pad_od}, {8'h0, ex});
            end
        end

        // R3, R4, R11: routing sweep
        for (int sel = 0; sel < 2; sel++) begin
            wr_reg(2'd0, sel ? 8'hC0 : 8'h80);
            for (int busy = 0; busy < 2; busy++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int r = 0; r < 2; r++) begin
                            int k;
                            logic [4:0] hit;
                            logic [7:0] exd;
                            if (a == 0 && w == 1) continue;
                            k = -1;
                            if (a == 1) k = sel ? 0 : 1;
                            if (a == 2) k = sel ? (busy ? 2 : 3) : 4;
                            hit = (k >= 0) ? 5'(1 << k) : 5'd0;
                            exd = (k >= 0) ? 8'(8'hA0 + 8'h11 * k)
                                           : ((a == 0) ? (sel ? 8'hC0 : 8'h80) : 8'h01);
                            @(negedge clk);
                            tw_bus_busy = busy[0]; cpu_addr = 2'(a);
                            cpu_wr = w[0]; cpu_rd = r[0]; cpu_wdata = 8'h3C;
                            #1;
                            chk(tgt_wr == (w ? hit : 5'd0),
                                (a == 1) ? "R3 status write route" : "R11 write strobe",
                                tgt_wr, w ? hit : 5'd0);
                            chk(tgt_rd == (r ? hit : 5'd0),
                                (a == 2) ? "R4 buffer read route" : "R11 read strobe",
                                tgt_rd, r ? hit : 5'd0);
                            chk(cpu_rdata == exd, (a == 2) ? "R4 buffer data" : "R3 read data",
                                cpu_rdata, exd);
                            #1 cpu_wr = 1'b0; cpu_rd = 1'b0;
                        end
                    end
                end
            end
        end

        // R6: interrupt sweep
        for (int m = 0; m < 4; m++) begin
            wr_reg(2'd0, {1'b1, m[1], 1'b0, m[0], 4'b0000});
            for (int s = 0; s < 32; s++) begin
                logic ex;
                {tw_ccf, tw_err, spi_ccf, spi_modf, spi_wcol} = 5'(s);
                ex = m[0] & (m[1] ? (tw_ccf | tw_err) : (spi_ccf | spi_modf | spi_wcol));
                #1 chk(irq == ex, "R6 interrupt", irq, ex);
            end
        end

        finish_run();
    end
endmodule